// File: doc/BRIEF.md
# Crystal Clock Failure Failover Controller

This block supervises an external crystal clock. It uses an always-running internal RC clock as the time base. The crystal clock drives a small free-running divider. The top bit of that divider crosses into the reference domain through a synchroniser, and every change of that bit counts as one activity event. The reference side counts these events over fixed windows of reference cycles. An armed window that closes with too few events is treated as a crystal failure.

A detected failure sets a sticky flag, and that flag also drives the non-maskable interrupt request. While the flag is set, the block takes over the clock-tree selections that software supplies:

- The crystal enable is dropped.
- A system clock taken from the crystal or from the PLL moves to the internal RC oscillator.
- A PLL fed from the crystal is switched off.
- An RTC selection naming the main crystal goes back to "no clock".

These overrides stay in place until software pulses the clear input. After the clear, the outputs again follow the software selections. The block never turns the crystal back on by itself.

All control inputs belong to the reference clock domain. Monitoring runs only while the monitor enable is set and the crystal enable output is high. Each time monitoring starts, the first two windows are only observed and never judged.

Top module: `xtal_failover`

## Requirements
- R1: While the failure flag is set, `xtal_en_o` is 0 regardless of `xtal_en_i`. While it is clear, `xtal_en_o` equals `xtal_en_i`.
- R2: A detected failure sets `flag_o` on the next reference edge. The flag stays set until a `flag_clr_i` pulse. If a failure and a clear happen in the same cycle, the failure wins.
- R3: `nmi_o` equals `flag_o` at all times, and it is 0 after reset.
- R4: System source encoding is 0 = internal RC, 1 = crystal, 2 = PLL, and 3 is passed through. While the flag is set, an input of 1 or 2 is output as 0. Any other value is passed unchanged.
- R5: PLL reference encoding is 0 = internal RC and 1 = crystal. While the flag is set and `pll_ref_i` is 1, `pll_en_o` is 0. Otherwise `pll_en_o` equals `pll_en_i`.
- R6: RTC source encoding is 0 = none, 1 = low-speed crystal, 2 = low-speed RC, 3 = main crystal. While the flag is set, 3 is output as 0. The other values pass unchanged.
- R7: The failure decision is made at the end of a 64-cycle window, counting changes of the synchronised divider bit. Fewer than 2 changes means failure. After the crystal stops, the flag rises within 2 windows plus synchroniser delay.
- R8: Detection is idle while `mon_en_i` is 0 or `xtal_en_o` is 0. On entering the active state, the first two windows are not judged. The earliest possible flag therefore appears after the 192nd active cycle.
- R9: No failure is declared while the crystal runs at any frequency from 1/4 to 4 times the reference.
- R10: After a clear with no new failure, every output follows its software input again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Internal RC reference clock |
| xtal_clk | input | 1 | Monitored crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_en_i | input | 1 | Failure monitor enable |
| xtal_en_i | input | 1 | Software crystal enable |
| sys_sel_i | input | 2 | Software system clock source |
| pll_ref_i | input | 1 | Software PLL reference source |
| pll_en_i | input | 1 | Software PLL enable |
| rtc_sel_i | input | 2 | Software RTC clock source |
| flag_clr_i | input | 1 | Single-cycle clear of the failure flag |
| xtal_en_o | output | 1 | Effective crystal enable |
| sys_sel_o | output | 2 | Effective system clock source |
| pll_en_o | output | 1 | Effective PLL enable |
| rtc_sel_o | output | 2 | Effective RTC clock source |
| flag_o | output | 1 | Sticky crystal failure flag |
| nmi_o | output | 1 | Non-maskable interrupt request |

## Verification
The bench builds the block with its default parameters: 64-cycle windows, a 2-event threshold, 2 arming windows and a 3-bit crystal divider. With 64-cycle windows, one stop-and-recover scenario takes about 400 reference cycles. That keeps the full set of 24 source-selection combinations short. The 3-bit divider slows a crystal running at 4 times the reference down to one event per reference cycle. This puts the 1/4× to 4× no-false-detection sweep within reach of ordinary simulated clocks. The arming count makes the exact 192-cycle boundary observable.

// File: rtl/xfo_pkg.sv
package xfo_pkg;
    typedef enum logic [1:0] {
        SYS_RC   = 2'd0,
        SYS_XTAL = 2'd1,
        SYS_PLL  = 2'd2,
        SYS_RSVD = 2'd3
    } sys_src_e;

    typedef enum logic [1:0] {
        RTC_NONE  = 2'd0,
        RTC_LXTAL = 2'd1,
        RTC_LRC   = 2'd2,
        RTC_MAIN  = 2'd3
    } rtc_src_e;

    localparam logic PLLREF_XTAL = 1'b1;
endpackage

// File: rtl/xfo_prescale.sv
module xfo_prescale #(
    parameter int PRE_W = 3
) (
    input  logic xtal_clk,
    input  logic rst_n,
    output logic tog_o
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge xtal_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tog_o = st_q.cnt[PRE_W-1];
endmodule

// File: rtl/xfo_detect.sv
module xfo_detect #(
    parameter int WIN_CYC   = 64,
    parameter int MIN_EDGES = 2,
    parameter int ARM_WIN   = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic tog_i,
    output logic fail_o
);
    localparam int WIN_W  = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam int EDGE_W = $clog2(MIN_EDGES + 1);
    localparam int ARM_W  = $clog2(ARM_WIN + 1);
    localparam logic [WIN_W-1:0]  WIN_LAST = WIN_W'(WIN_CYC - 1);
    localparam logic [EDGE_W-1:0] EDGE_MAX = EDGE_W'(MIN_EDGES);
    localparam logic [ARM_W-1:0]  ARM_MAX  = ARM_W'(ARM_WIN);

    typedef struct packed {
        logic [2:0]        sync;
        logic [WIN_W-1:0]  win;
        logic [EDGE_W-1:0] edges;
        logic [ARM_W-1:0]  arm;
    } det_t;

    det_t st_d, st_q;
    logic              edge_now;
    logic [EDGE_W-1:0] total;
    logic              fail;

    always_comb begin
        st_d      = st_q;
        fail      = 1'b0;
        st_d.sync = {st_q.sync[1:0], tog_i};
        edge_now  = st_q.sync[2] ^ st_q.sync[1];
        total     = st_q.edges;
        if (edge_now && (st_q.edges != EDGE_MAX))
            total = st_q.edges + 1'b1;

        if (!active_i) begin
            st_d.win   = '0;
            st_d.edges = '0;
            st_d.arm   = '0;
        end else if (st_q.win == WIN_LAST) begin
            fail       = (st_q.arm == ARM_MAX) && (total < EDGE_MAX);
            st_d.win   = '0;
            st_d.edges = '0;
            if (st_q.arm != ARM_MAX)
                st_d.arm = st_q.arm + 1'b1;
        end else begin
            st_d.win   = st_q.win + 1'b1;
            st_d.edges = total;
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fail_o = fail;

    p_edge_sat_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        st_q.edges <= EDGE_MAX);

    p_fail_after_arm_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        fail_o |-> $past(active_i));
endmodule

// File: rtl/xfo_override.sv
module xfo_override
    import xfo_pkg::*;
(
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic       fail_i,
    input  logic       clr_i,
    input  logic       xtal_en_i,
    input  logic [1:0] sys_sel_i,
    input  logic       pll_ref_i,
    input  logic       pll_en_i,
    input  logic [1:0] rtc_sel_i,
    output logic       xtal_en_o,
    output logic [1:0] sys_sel_o,
    output logic       pll_en_o,
    output logic [1:0] rtc_sel_o,
    output logic       flag_o
);
    typedef struct packed {
        logic flag;
    } ovr_t;

    ovr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fail_i)     st_d.flag = 1'b1;
        else if (clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        xtal_en_o = xtal_en_i && !st_q.flag;
        sys_sel_o = sys_sel_i;
        if (st_q.flag && (sys_sel_i == SYS_XTAL || sys_sel_i == SYS_PLL))
            sys_sel_o = SYS_RC;
        pll_en_o  = pll_en_i && !(st_q.flag && pll_ref_i == PLLREF_XTAL);
        rtc_sel_o = rtc_sel_i;
        if (st_q.flag && rtc_sel_i == RTC_MAIN)
            rtc_sel_o = RTC_NONE;
    end

    assign flag_o = st_q.flag;

    p_flag_sticky_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        st_q.flag && !clr_i |=> st_q.flag);

    p_flag_cause_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(fail_i));
endmodule

// File: rtl/xtal_failover.sv
module xtal_failover
    import xfo_pkg::*;
#(
    parameter int WIN_CYC   = 64,
    parameter int MIN_EDGES = 2,
    parameter int ARM_WIN   = 2,
    parameter int PRE_W     = 3
) (
    input  logic       ref_clk,
    input  logic       xtal_clk,
    input  logic       rst_n,
    input  logic       mon_en_i,
    input  logic       xtal_en_i,
    input  logic [1:0] sys_sel_i,
    input  logic       pll_ref_i,
    input  logic       pll_en_i,
    input  logic [1:0] rtc_sel_i,
    input  logic       flag_clr_i,
    output logic       xtal_en_o,
    output logic [1:0] sys_sel_o,
    output logic       pll_en_o,
    output logic [1:0] rtc_sel_o,
    output logic       flag_o,
    output logic       nmi_o
);
    logic tog;
    logic det_fail;
    logic active;
    logic flag;

    assign active = mon_en_i && xtal_en_o;

    xfo_prescale #(.PRE_W(PRE_W)) u_pre (
        .xtal_clk (xtal_clk),
        .rst_n    (rst_n),
        .tog_o    (tog)
    );

    xfo_detect #(
        .WIN_CYC   (WIN_CYC),
        .MIN_EDGES (MIN_EDGES),
        .ARM_WIN   (ARM_WIN)
    ) u_det (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .active_i (active),
        .tog_i    (tog),
        .fail_o   (det_fail)
    );

    xfo_override u_ovr (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .fail_i    (det_fail),
        .clr_i     (flag_clr_i),
        .xtal_en_i (xtal_en_i),
        .sys_sel_i (sys_sel_i),
        .pll_ref_i (pll_ref_i),
        .pll_en_i  (pll_en_i),
        .rtc_sel_i (rtc_sel_i),
        .xtal_en_o (xtal_en_o),
        .sys_sel_o (sys_sel_o),
        .pll_en_o  (pll_en_o),
        .rtc_sel_o (rtc_sel_o),
        .flag_o    (flag)
    );

    assign flag_o = flag;
    assign nmi_o  = flag;

    p_xtal_off_r1: assert property (@(posedge ref_clk) disable iff (!rst_n)
        nmi_o |-> !xtal_en_o);

    p_sys_forced_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        nmi_o |-> (sys_sel_o != SYS_XTAL && sys_sel_o != SYS_PLL));

    p_pll_off_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        nmi_o && pll_ref_i == PLLREF_XTAL |-> !pll_en_o);

    p_rtc_none_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        nmi_o && rtc_sel_i == RTC_MAIN |-> rtc_sel_o == RTC_NONE);

    p_quiet_off_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !mon_en_i |-> !det_fail);
endmodule

// File: tb/xtal_failover_test.sv
`timescale 1ns/100ps
module xtal_failover_test;
    logic       ref_clk = 1'b0;
    logic       xtal_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mon_en = 1'b0;
    logic       xen = 1'b1;
    logic [1:0] sys_sel = 2'd0;
    logic       pll_ref = 1'b0;
    logic       pll_en = 1'b1;
    logic [1:0] rtc_sel = 2'd0;
    logic       clr = 1'b0;
    logic       xen_o, pll_en_o, flag_o, nmi_o;
    logic [1:0] sys_o, rtc_o;

    real xhalf = 13.5;
    bit  xrun  = 1'b1;
    int  n_chk = 0;
    int  n_bad = 0;

    xtal_failover uut (
        .ref_clk(ref_clk), .xtal_clk(xtal_clk), .rst_n(rst_n),
        .mon_en_i(mon_en), .xtal_en_i(xen), .sys_sel_i(sys_sel),
        .pll_ref_i(pll_ref), .pll_en_i(pll_en), .rtc_sel_i(rtc_sel),
        .flag_clr_i(clr), .xtal_en_o(xen_o), .sys_sel_o(sys_o),
        .pll_en_o(pll_en_o), .rtc_sel_o(rtc_o), .flag_o(flag_o), .nmi_o(nmi_o)
    );

    always #10 ref_clk = ~ref_clk;

    initial begin
        #1.3;
        forever begin
            if (xrun) begin
                #(xhalf) xtal_clk = ~xtal_clk;
            end else begin
                #1.0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse_clear();
        @(negedge ref_clk) clr = 1'b1;
        @(negedge ref_clk) clr = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge ref_clk);
        rst_n = 1'b1;
        @(negedge ref_clk);
        check(flag_o == 1'b0, "R2 reset flag", flag_o, 0);
        check(nmi_o == 1'b0, "R3 reset nmi", nmi_o, 0);
        check(xen_o == 1'b1, "R1 reset crystal enable", xen_o, 1);
        check(sys_o == sys_sel, "R4 reset system source", sys_o, sys_sel);
        mon_en = 1'b1;
    endtask

    task automatic t_no_false(input real half);
        xhalf = half;
        xrun  = 1'b1;
        repeat (640) @(negedge ref_clk);
        check(flag_o == 1'b0, "R9 running crystal gives no failure", flag_o, 0);
    endtask

    task automatic t_stop(input int s, input int r, input int t);
        int exp_sys, exp_pll, exp_rtc;
        @(negedge ref_clk);
        sys_sel = 2'(s);
        pll_ref = 1'(r);
        rtc_sel = 2'(t);
        pll_en  = 1'b1;
        xrun    = 1'b1;
        repeat (260) @(negedge ref_clk);
        check(flag_o == 1'b0, "R9 no failure before stop", flag_o, 0);
        xrun = 1'b0;
        for (int i = 0; i < 140 && !nmi_o; i++) @(negedge ref_clk);
        check(nmi_o == 1'b1, "R7 failure within two windows", nmi_o, 1);
        exp_sys = (s == 1 || s == 2) ? 0 : s;
        exp_pll = (r == 1) ? 0 : 1;
        exp_rtc = (t == 3) ? 0 : t;
        check(xen_o == 1'b0, "R1 crystal disabled", xen_o, 0);
        check(flag_o == nmi_o, "R3 nmi matches flag", nmi_o, flag_o);
        check(sys_o == 2'(exp_sys), "R4 system source override", sys_o, exp_sys);
        check(pll_en_o == 1'(exp_pll), "R5 PLL enable override", pll_en_o, exp_pll);
        check(rtc_o == 2'(exp_rtc), "R6 RTC source override", rtc_o, exp_rtc);
        xrun = 1'b1;
        repeat (20) @(negedge ref_clk);
        check(flag_o == 1'b1, "R2 flag sticky", flag_o, 1);
        check(xen_o == 1'b0, "R1 crystal stays off", xen_o, 0);
        pulse_clear();
        check(flag_o == 1'b0, "R2 flag cleared", flag_o, 0);
        check(xen_o == 1'b1 && sys_o == 2'(s) && pll_en_o == 1'b1 && rtc_o == 2'(t),
              "R10 outputs follow inputs", {xen_o, sys_o, pll_en_o, rtc_o}, {1'b1, 2'(s), 1'b1, 2'(t)});
    endtask

    task automatic t_monitor();
        @(negedge ref_clk);
        sys_sel = 2'd1;
        xrun    = 1'b0;
        mon_en  = 1'b0;
        repeat (300) @(negedge ref_clk);
        check(flag_o == 1'b0, "R8 idle with monitor off", flag_o, 0);
        mon_en = 1'b1;
        repeat (180) @(negedge ref_clk);
        check(flag_o == 1'b0, "R8 unarmed windows not judged", flag_o, 0);
        repeat (14) @(negedge ref_clk);
        check(flag_o == 1'b1, "R8 first judged window fails", flag_o, 1);
        xen = 1'b0;
        pulse_clear();
        repeat (300) @(negedge ref_clk);
        check(flag_o == 1'b0, "R8 idle with crystal disabled", flag_o, 0);
        check(xen_o == 1'b0, "R1 disabled input passes", xen_o, 0);
        xen  = 1'b1;
        xrun = 1'b1;
        repeat (10) @(negedge ref_clk);
        check(xen_o == 1'b1, "R10 crystal enable follows input", xen_o, 1);
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_no_false(40.0);
        t_no_false(23.5);
        t_no_false(10.0);
        t_no_false(6.5);
        t_no_false(2.5);
        xhalf = 13.5;
        for (int s = 0; s < 3; s++)
            for (int r = 0; r < 2; r++)
                for (int t = 0; t < 4; t++)
                    t_stop(s, r, t);
        t_monitor();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule